// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block sits between the clock sources of a clock generator and its output pins and decides, for each output group, whether pulses get through. It has three active-low control inputs that may change at any time: one stops the processor group (the CPU-rate output and the 66 MHz output), one stops the PCI group, and one powers the whole generator down. Each control is synchronized in the clock domain it affects. The enable for each output is then updated only while that clock is low, so an output always stops at a low level and restarts with a full high phase.

Power down overrides both stop inputs. It parks every output, including the free-running PCI, reference and interrupt-controller outputs, and drops the oscillator/VCO run flag. When power down is released, each domain keeps its outputs low until a settle counter expires, which models the time the sources need to stabilize. Reset is treated like a power-down period. The free-running PCI, reference and interrupt-controller outputs are derived from the PCI-rate source. The processor and 66 MHz outputs are derived from the CPU-rate source.

Top module: `clkstop_ctrl`

## Requirements
- R1: Driving `cpu_halt_n` low parks `cpu_clk_o` and `m66_clk_o` low. If the change lands in a low phase of `clk_cpu`, both outputs still pulse after the first and second rising edges that follow it. The pulse after the third rising edge is the first one removed.
- R2: Driving `cpu_halt_n` high again, with power down inactive and settled, restores both outputs with the same latency. The third rising edge of `clk_cpu` after the change is the first one to pulse, and both outputs run from then on.
- R3: Driving `pci_halt_n` low parks `pci_clk_o` low. The removal takes effect from the third rising edge of `clk_pci` after the change, and release brings the pulses back with the same latency. While this happens, `pcif_clk_o`, `ref_clk_o` and `apic_clk_o` keep pulsing.
- R4: The CPU stop input has no effect on the PCI-domain outputs, and the PCI stop input has no effect on `cpu_clk_o` or `m66_clk_o`.
- R5: While `pwrdn_n` is low, all six clock outputs are low from the third rising edge of their own clock after the fall, whatever the two stop inputs do. `osc_run_o` is also low.
- R6: `osc_run_o` is a registered output equal to `pwrdn_n` as it stood at the `clk_pci` rising edge three edges earlier. It therefore changes after the third `clk_pci` rising edge following a change of `pwrdn_n`.
- R7: After `pwrdn_n` rises, each domain counts its own rising edges from the change. Its outputs stay low up to and including edge SETTLE_CYC+2, and the first pulse appears at edge SETTLE_CYC+3 (edge 19 with the default of 16).
- R8: While `rst` is high (from the second rising edge of each clock on), every clock output and `osc_run_o` are low. Release of `rst` with `pwrdn_n` high behaves as a power-down release with R7 timing.
- R9: A gated output is never high while its source clock is low. A gated output is either high for the whole high phase of its source or low for all of it, so there are no runt pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU-rate source clock; drives the processor and 66 MHz outputs |
| clk_pci | input | 1 | PCI-rate source clock; drives the PCI, free PCI, reference and interrupt-controller outputs |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| cpu_halt_n | input | 1 | Active-low asynchronous stop for the processor and 66 MHz outputs |
| pci_halt_n | input | 1 | Active-low asynchronous stop for the PCI output |
| pwrdn_n | input | 1 | Active-low asynchronous power down; overrides both stops |
| cpu_clk_o | output | 1 | Gated processor clock |
| m66_clk_o | output | 1 | Gated 66 MHz clock, stopped together with the processor clock |
| pci_clk_o | output | 1 | Gated PCI clock |
| pcif_clk_o | output | 1 | Free-running PCI clock, parked only by power down or reset |
| ref_clk_o | output | 1 | Reference clock output, parked only by power down or reset |
| apic_clk_o | output | 1 | Interrupt-controller clock output, parked only by power down or reset |
| osc_run_o | output | 1 | Registered oscillator/VCO run flag |

## Verification
On every cycle, the checker confirms three things. A stop or power-down level held for four samples leaves the affected outputs low. An enable that was live at the previous falling edge produces a pulse. The run flag trails `pwrdn_n` by exactly three PCI edges. The rising-edge checks show that no gated output is high just before its source rises. The exact edge counts of stop and restart, the settle window of SETTLE_CYC+2 low edges, and the isolation between the two domains can only be shown by the bench's scenarios. In those scenarios the controls change at a known phase, and individual pulses are counted against bench-computed expectations.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned SETTLE_DEF     = 16;

  typedef enum logic {
    GATE_PARK = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_e;
endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer; resets to 0, i.e. the asserted level of an active-low control.
module cs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cs_settle.sv
`timescale 1ns/1ps
// Counts CYC cycles with hold low, then raises done until hold returns.
module cs_settle #(
  parameter int unsigned CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic done
);
  localparam int unsigned CW = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/cs_domain.sv
`timescale 1ns/1ps
// One clock domain: synchronizes power down and a stop request, runs the settle counter.
module cs_domain #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrdn_n,
  input  logic stop_n,
  output logic ready,
  output logic run
);
  logic pwr_ok_s;
  logic stop_n_s;
  logic settled;

  cs_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwrdn_n),
    .q   (pwr_ok_s)
  );

  cs_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk (clk),
    .rst (rst),
    .d   (stop_n),
    .q   (stop_n_s)
  );

  cs_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .hold (!pwr_ok_s),
    .done (settled)
  );

  assign ready = settled & pwr_ok_s;
  assign run   = ready & stop_n_s;
endmodule

// File: rtl/cs_gate.sv
`timescale 1ns/1ps
// Glitch-free gate cells: the enable is captured on the falling edge, so it only moves while the source is low.
module cs_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned N = 1
) (
  input  logic         clk_src,
  input  logic         rst,
  input  logic         en,
  output logic [N-1:0] clk_o
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    gate_state_e st_q;

    always_ff @(negedge clk_src) begin
      if (rst) st_q <= GATE_PARK;
      else     st_q <= en ? GATE_RUN : GATE_PARK;
    end

    assign clk_o[i] = clk_src & (st_q == GATE_RUN);
  end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF,
  parameter int unsigned SETTLE_CYC  = SETTLE_DEF
) (
  input  logic clk_cpu,
  input  logic clk_pci,
  input  logic rst,
  input  logic cpu_halt_n,
  input  logic pci_halt_n,
  input  logic pwrdn_n,
  output logic cpu_clk_o,
  output logic m66_clk_o,
  output logic pci_clk_o,
  output logic pcif_clk_o,
  output logic ref_clk_o,
  output logic apic_clk_o,
  output logic osc_run_o
);
  localparam int unsigned N_CPU_GRP  = 2;
  localparam int unsigned N_FREE_GRP = 3;

  logic                  cpu_ready_w;
  logic                  cpu_run_w;
  logic                  pci_ready_w;
  logic                  pci_run_w;
  logic                  osc_ok_s;
  logic                  osc_q;
  logic [N_CPU_GRP-1:0]  cpu_grp;
  logic [N_FREE_GRP-1:0] free_grp;
  logic [0:0]            pci_grp;

  cs_domain #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_CYC(SETTLE_CYC)) u_cpu_dom (
    .clk     (clk_cpu),
    .rst     (rst),
    .pwrdn_n (pwrdn_n),
    .stop_n  (cpu_halt_n),
    .ready   (cpu_ready_w),
    .run     (cpu_run_w)
  );

  cs_domain #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_CYC(SETTLE_CYC)) u_pci_dom (
    .clk     (clk_pci),
    .rst     (rst),
    .pwrdn_n (pwrdn_n),
    .stop_n  (pci_halt_n),
    .ready   (pci_ready_w),
    .run     (pci_run_w)
  );

  cs_gate #(.N(N_CPU_GRP)) u_cpu_gate (
    .clk_src (clk_cpu),
    .rst     (rst),
    .en      (cpu_run_w),
    .clk_o   (cpu_grp)
  );

  cs_gate #(.N(1)) u_pci_gate (
    .clk_src (clk_pci),
    .rst     (rst),
    .en      (pci_run_w),
    .clk_o   (pci_grp)
  );

  cs_gate #(.N(N_FREE_GRP)) u_free_gate (
    .clk_src (clk_pci),
    .rst     (rst),
    .en      (pci_ready_w),
    .clk_o   (free_grp)
  );

  // Run flag has its own synchronizer so it does not wait for the settle counter.
  cs_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
    .clk (clk_pci),
    .rst (rst),
    .d   (pwrdn_n),
    .q   (osc_ok_s)
  );

  always_ff @(posedge clk_pci) begin
    if (rst) osc_q <= 1'b0;
    else     osc_q <= osc_ok_s;
  end

  assign cpu_clk_o  = cpu_grp[0];
  assign m66_clk_o  = cpu_grp[1];
  assign pci_clk_o  = pci_grp[0];
  assign pcif_clk_o = free_grp[0];
  assign ref_clk_o  = free_grp[1];
  assign apic_clk_o = free_grp[2];
  assign osc_run_o  = osc_q;
endmodule

// File: rtl/clkstop_chk.sv
`timescale 1ns/1ps
module clkstop_chk (
  input logic clk_cpu,
  input logic clk_pci,
  input logic rst,
  input logic cpu_halt_n,
  input logic pci_halt_n,
  input logic pwrdn_n,
  input logic cpu_clk_o,
  input logic m66_clk_o,
  input logic pci_clk_o,
  input logic pcif_clk_o,
  input logic ref_clk_o,
  input logic apic_clk_o,
  input logic osc_run_o,
  input logic cpu_run,
  input logic pci_run,
  input logic pci_ready
);
  logic [2:0] age_cn;
  logic [2:0] age_pn;
  logic [2:0] age_pp;

  always_ff @(negedge clk_cpu) begin
    if (rst) age_cn <= '0;
    else if (age_cn != 3'd7) age_cn <= age_cn + 3'd1;
  end

  always_ff @(negedge clk_pci) begin
    if (rst) age_pn <= '0;
    else if (age_pn != 3'd7) age_pn <= age_pn + 3'd1;
  end

  always_ff @(posedge clk_pci) begin
    if (rst) age_pp <= '0;
    else if (age_pp != 3'd7) age_pp <= age_pp + 3'd1;
  end

  AST_CPU_PARKED: assert property (@(negedge clk_cpu) disable iff (rst)
    (age_cn >= 3'd4 && !cpu_halt_n && !$past(cpu_halt_n) && !$past(cpu_halt_n, 2) && !$past(cpu_halt_n, 3))
      |-> (!cpu_clk_o && !m66_clk_o)); // R1

  AST_CPU_RESUMED: assert property (@(negedge clk_cpu) disable iff (rst)
    (age_cn >= 3'd4 && $past(cpu_run)) |-> (cpu_clk_o && m66_clk_o)); // R2

  AST_CPU_NEEDS_REQ: assert property (@(negedge clk_cpu) disable iff (rst)
    (age_cn >= 3'd4 && cpu_clk_o) |-> ($past(cpu_halt_n, 2) && $past(pwrdn_n, 2))); // R4

  AST_PCI_PARKED: assert property (@(negedge clk_pci) disable iff (rst)
    (age_pn >= 3'd4 && !pci_halt_n && !$past(pci_halt_n) && !$past(pci_halt_n, 2) && !$past(pci_halt_n, 3))
      |-> !pci_clk_o); // R3

  AST_PCI_FREE_RUN: assert property (@(negedge clk_pci) disable iff (rst)
    (age_pn >= 3'd4 && $past(pci_ready)) |-> (pcif_clk_o && ref_clk_o && apic_clk_o)); // R3

  AST_PCI_RESUMED: assert property (@(negedge clk_pci) disable iff (rst)
    (age_pn >= 3'd4 && $past(pci_run)) |-> pci_clk_o); // R3

  AST_PD_CPU_QUIET: assert property (@(negedge clk_cpu) disable iff (rst)
    (age_cn >= 3'd4 && !pwrdn_n && !$past(pwrdn_n) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 3))
      |-> (!cpu_clk_o && !m66_clk_o)); // R5

  AST_PD_PCI_QUIET: assert property (@(negedge clk_pci) disable iff (rst)
    (age_pn >= 3'd4 && !pwrdn_n && !$past(pwrdn_n) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 3))
      |-> (!pci_clk_o && !pcif_clk_o && !ref_clk_o && !apic_clk_o && !osc_run_o)); // R5

  AST_OSC_LAG: assert property (@(posedge clk_pci) disable iff (rst)
    (age_pp >= 3'd4) |-> (osc_run_o == $past(pwrdn_n, 3))); // R6

  AST_NO_RUNT_CPU: assert property (@(posedge clk_cpu) disable iff (rst)
    (!cpu_clk_o && !m66_clk_o)); // R9

  AST_NO_RUNT_PCI: assert property (@(posedge clk_pci) disable iff (rst)
    (!pci_clk_o && !pcif_clk_o && !ref_clk_o && !apic_clk_o)); // R9
endmodule

bind clkstop_ctrl clkstop_chk u_clkstop_chk (
  .clk_cpu    (clk_cpu),
  .clk_pci    (clk_pci),
  .rst        (rst),
  .cpu_halt_n (cpu_halt_n),
  .pci_halt_n (pci_halt_n),
  .pwrdn_n    (pwrdn_n),
  .cpu_clk_o  (cpu_clk_o),
  .m66_clk_o  (m66_clk_o),
  .pci_clk_o  (pci_clk_o),
  .pcif_clk_o (pcif_clk_o),
  .ref_clk_o  (ref_clk_o),
  .apic_clk_o (apic_clk_o),
  .osc_run_o  (osc_run_o),
  .cpu_run    (cpu_run_w),
  .pci_run    (pci_run_w),
  .pci_ready  (pci_ready_w)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;
  localparam real CPU_HALF = 5.0;
  localparam real PCI_HALF = 15.0;
  localparam int  SETTLE   = 16;
  localparam real WATCHDOG = 1500000.0;

  logic clk_cpu = 1'b0;
  logic clk_pci = 1'b0;
  logic rst = 1'b1;
  logic cpu_halt_n = 1'b1;
  logic pci_halt_n = 1'b1;
  logic pwrdn_n = 1'b1;
  logic cpu_clk_o, m66_clk_o, pci_clk_o, pcif_clk_o, ref_clk_o, apic_clk_o, osc_run_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CPU_HALF) clk_cpu = ~clk_cpu;
  always #(PCI_HALF) clk_pci = ~clk_pci;

  clkstop_ctrl #(.SETTLE_CYC(SETTLE)) i_clkstop_ctrl (
    .clk_cpu    (clk_cpu),
    .clk_pci    (clk_pci),
    .rst        (rst),
    .cpu_halt_n (cpu_halt_n),
    .pci_halt_n (pci_halt_n),
    .pwrdn_n    (pwrdn_n),
    .cpu_clk_o  (cpu_clk_o),
    .m66_clk_o  (m66_clk_o),
    .pci_clk_o  (pci_clk_o),
    .pcif_clk_o (pcif_clk_o),
    .ref_clk_o  (ref_clk_o),
    .apic_clk_o (apic_clk_o),
    .osc_run_o  (osc_run_o)
  );

  function automatic void check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endfunction

  // Expected pulse state of a gated output; -1 while a control is still in flight.
  function automatic int exp_gated(input logic pd_n, input int pd_age, input logic stop_n, input int stop_age);
    if (pd_age < 3) return -1;
    if (!pd_n) return 0;
    if (pd_age <= SETTLE + 2) return 0;
    if (stop_age < 3) return -1;
    return int'(stop_n);
  endfunction

  function automatic int exp_osc(input logic pd_n, input int pd_age);
    if (pd_age < 3) return -1;
    return int'(pd_n);
  endfunction

  function automatic logic pci_side(input int sel);
    case (sel)
      0: return pci_clk_o;
      1: return pcif_clk_o;
      2: return ref_clk_o;
      3: return apic_clk_o;
      default: return osc_run_o;
    endcase
  endfunction

  // CPU-domain monitor
  logic cm_pd_prev, cm_h_prev;
  int   cm_pd_age, cm_h_age;
  always @(posedge clk_cpu) begin
    if (rst) begin
      cm_pd_prev = 1'b0; cm_h_prev = 1'b0; cm_pd_age = 0; cm_h_age = 0;
    end else begin
      cm_pd_age = (pwrdn_n !== cm_pd_prev) ? 1 : cm_pd_age + 1;
      cm_h_age  = (cpu_halt_n !== cm_h_prev) ? 1 : cm_h_age + 1;
      cm_pd_prev = pwrdn_n;
      cm_h_prev  = cpu_halt_n;
      begin
        int e;
        string tag;
        e = exp_gated(cm_pd_prev, cm_pd_age, cm_h_prev, cm_h_age);
        tag = !cm_pd_prev ? "R5" : (cm_pd_age <= SETTLE + 2) ? "R7" : (cm_h_prev ? "R2" : "R1");
        #(CPU_HALF / 2.0);
        if (e >= 0) begin
          check(tag, "cpu_clk_o", cpu_clk_o, e[0]);
          check(tag, "m66_clk_o", m66_clk_o, e[0]);
        end
        #(CPU_HALF - 0.5);
        check("R9", "cpu group low phase", cpu_clk_o | m66_clk_o, 1'b0);
      end
    end
  end

  // PCI-domain monitor
  logic pm_pd_prev, pm_h_prev;
  int   pm_pd_age, pm_h_age;
  always @(posedge clk_pci) begin
    if (rst) begin
      pm_pd_prev = 1'b0; pm_h_prev = 1'b0; pm_pd_age = 0; pm_h_age = 0;
    end else begin
      pm_pd_age = (pwrdn_n !== pm_pd_prev) ? 1 : pm_pd_age + 1;
      pm_h_age  = (pci_halt_n !== pm_h_prev) ? 1 : pm_h_age + 1;
      pm_pd_prev = pwrdn_n;
      pm_h_prev  = pci_halt_n;
      begin
        int ep, ef, eo;
        ep = exp_gated(pm_pd_prev, pm_pd_age, pm_h_prev, pm_h_age);
        ef = exp_gated(pm_pd_prev, pm_pd_age, 1'b1, 1000);
        eo = exp_osc(pm_pd_prev, pm_pd_age);
        #(PCI_HALF / 2.0);
        if (ep >= 0) check("R3", "pci_clk_o", pci_clk_o, ep[0]);
        if (ef >= 0) begin
          check("R3", "pcif_clk_o", pcif_clk_o, ef[0]);
          check("R3", "ref_clk_o", ref_clk_o, ef[0]);
          check("R3", "apic_clk_o", apic_clk_o, ef[0]);
        end
        if (eo >= 0) check("R6", "osc_run_o", osc_run_o, eo[0]);
        #(PCI_HALF - 0.5);
        check("R9", "pci group low phase", pci_clk_o | pcif_clk_o | ref_clk_o | apic_clk_o, 1'b0);
      end
    end
  end

  // Controls change only in the low phase of both clocks, just after a falling edge.
  task automatic set_ctrl(input logic h_cpu, input logic h_pci, input logic pd);
    @(posedge clk_pci);
    #(PCI_HALF + 2.5);
    cpu_halt_n = h_cpu;
    pci_halt_n = h_pci;
    pwrdn_n    = pd;
  endtask

  task automatic set_rst(input logic v);
    @(posedge clk_pci);
    #(PCI_HALF + 2.5);
    rst = v;
  endtask

  task automatic walk_cpu(input int last, input int flip, input logic old_v, input logic new_v, input string req);
    for (int e = 1; e <= last; e++) begin
      @(posedge clk_cpu);
      #(CPU_HALF / 2.0);
      check(req, $sformatf("cpu_clk_o edge %0d", e), cpu_clk_o, (e >= flip) ? new_v : old_v);
      check(req, $sformatf("m66_clk_o edge %0d", e), m66_clk_o, (e >= flip) ? new_v : old_v);
    end
  endtask

  task automatic walk_pci(input int last, input int flip, input logic old_v, input logic new_v,
                          input int sel, input string req);
    for (int e = 1; e <= last; e++) begin
      @(posedge clk_pci);
      #(PCI_HALF / 2.0);
      check(req, $sformatf("pci-side output %0d edge %0d", sel, e), pci_side(sel), (e >= flip) ? new_v : old_v);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_C10C));
    // R8: outputs quiet during reset
    repeat (3) @(posedge clk_pci);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_cpu);
      #(CPU_HALF / 2.0);
      check("R8", "cpu_clk_o in reset", cpu_clk_o, 1'b0);
    end
    @(posedge clk_pci);
    #(PCI_HALF / 2.0);
    check("R8", "pcif_clk_o in reset", pcif_clk_o, 1'b0);
    check("R8", "osc_run_o in reset", osc_run_o, 1'b0);
    // R8: release follows settle timing
    set_rst(1'b0);
    fork
      walk_cpu(SETTLE + 3, SETTLE + 3, 1'b0, 1'b1, "R8");
      walk_pci(SETTLE + 3, SETTLE + 3, 1'b0, 1'b1, 2, "R8");
    join
    repeat (2) @(posedge clk_pci);
    // R1 stop latency; R4 PCI side unaffected
    set_ctrl(1'b0, 1'b1, 1'b1);
    fork
      walk_cpu(5, 3, 1'b1, 1'b0, "R1");
      walk_pci(3, 1, 1'b1, 1'b1, 0, "R4");
    join
    // R2 restart latency
    set_ctrl(1'b1, 1'b1, 1'b1);
    walk_cpu(5, 3, 1'b0, 1'b1, "R2");
    // R3 PCI stop with free group running; R4 CPU side unaffected
    set_ctrl(1'b1, 1'b0, 1'b1);
    fork
      walk_pci(4, 3, 1'b1, 1'b0, 0, "R3");
      walk_pci(4, 1, 1'b1, 1'b1, 1, "R3");
      walk_pci(4, 1, 1'b1, 1'b1, 3, "R3");
      walk_cpu(6, 1, 1'b1, 1'b1, "R4");
    join
    set_ctrl(1'b1, 1'b1, 1'b1);
    walk_pci(4, 3, 1'b0, 1'b1, 0, "R3");
    // R5 power down overrides everything
    set_ctrl(1'b1, 1'b1, 1'b0);
    fork
      walk_cpu(4, 3, 1'b1, 1'b0, "R5");
      walk_pci(4, 3, 1'b1, 1'b0, 1, "R5");
      walk_pci(4, 3, 1'b1, 1'b0, 4, "R5");
    join
    set_ctrl(1'b0, 1'b0, 1'b0);
    set_ctrl(1'b1, 1'b1, 1'b0);
    fork
      walk_cpu(4, 1, 1'b0, 1'b0, "R5");
      walk_pci(4, 1, 1'b0, 1'b0, 0, "R5");
      walk_pci(4, 1, 1'b0, 1'b0, 2, "R5");
    join
    // R6 run flag lag and R7 settle window in both domains
    set_ctrl(1'b1, 1'b1, 1'b1);
    fork
      walk_cpu(SETTLE + 4, SETTLE + 3, 1'b0, 1'b1, "R7");
      walk_pci(SETTLE + 4, SETTLE + 3, 1'b0, 1'b1, 3, "R7");
      walk_pci(4, 3, 1'b0, 1'b1, 4, "R6");
    join
    // R8 reset in mid-run
    set_rst(1'b1);
    fork
      walk_cpu(4, 2, 1'b1, 1'b0, "R8");
      walk_pci(3, 1, 1'b1, 1'b0, 4, "R8");
    join
    set_rst(1'b0);
    fork
      walk_cpu(SETTLE + 3, SETTLE + 3, 1'b0, 1'b1, "R8");
      walk_pci(SETTLE + 3, SETTLE + 3, 1'b0, 1'b1, 1, "R8");
    join
    // Random phase, checked by the monitors
    for (int it = 0; it < 220; it++) begin
      set_ctrl(1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 6) != 0));
      repeat (2 + ($urandom % 30)) @(posedge clk_pci);
    end
    set_ctrl(1'b1, 1'b1, 1'b1);
    repeat (SETTLE + 6) @(posedge clk_pci);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(WATCHDOG);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule